// File: doc/BRIEF.md
# Dual-Issue In-Order Issue Unit

This block sits between instruction fetch and two execution pipes, named even and odd. It takes in a pair of 32-bit instructions and holds it. Each cycle it decides whether both instructions can leave together, or whether they must leave one at a time in program order. Each issued instruction is routed to the pipe its opcode names. The block never renames registers and never reorders instructions.

For every issued instruction it drives read requests to a 128-entry vector register file. The file has six read ports, three per pipe. A source whose value is being written back in the same cycle is marked for forwarding, and the forward names which write port carries the value. A per-register countdown tracks results still in flight. A delay line per pipe drives the file's two write ports, one for each pipe.

Pairs arrive on a valid/ready stream. The block raises ready only when no instruction of the current pair will remain after this cycle. If the pair is stalled, the upstream must hold the pair and keep valid high.

Top module: `pair_issue_unit`

## Requirements
- R1: The instruction fields are as follows:
  - bit 31 is the pipe class (0 = even, 1 = odd);
  - bits 30:28 are the source count, where values above 3 act as 3;
  - bits 27:21 are the target register;
  - bits 13:7, 20:14 and 6:0 are source slots 0, 1 and 2.
  
  A count of n uses slots 0 to n-1.
- R2: Every issued instruction appears on the output of its own class: ev_valid/ev_insn for even, od_valid/od_insn for odd.
- R3: Both instructions of a pair issue in the same cycle only when all of these hold:
  - the first is even and the second is odd;
  - the second uses no source equal to the first's target;
  - the two targets differ;
  - both are ready.
  
  Otherwise the first issues alone.
- R4: The second instruction of a pair never issues before the first; when the first leaves alone, the second issues in a later cycle.
- R5: An instruction waits while one of its used sources is the target of an in-flight instruction. Its earliest issue is the cycle in which that result is written: EVEN_LAT (3) cycles after an even issue, or ODD_LAT (2) cycles after an odd issue.
- R6: Source slots beyond the source count take no part in any hazard check.
- R7: An instruction whose target is still in flight waits until the write cycle of the older result.
- R8: Read ports 0 to 2 serve the even pipe and ports 3 to 5 serve the odd pipe. Port 3p+k carries source slot k of the instruction issuing on pipe p. A port is enabled only for used slots, and only in a cycle when that pipe issues.
- R9: rd_fwd is high on an enabled port whose register a write port is writing in the same cycle. rd_fwd_src then names that write port (0 = even, 1 = odd).
- R10: Write port p raises wr_en[p] with the instruction's target exactly its pipe latency after issue. The two write ports never name the same register in one cycle.
- R11: in_ready is high when no pending instruction will remain after this cycle, and low otherwise. An accepted pair can begin issuing in the next cycle.
- R12: After reset, in_ready is high and nothing issues, reads or writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction pair offered |
| in_ready | output | 1 | Pair will be taken at this edge |
| in_insn0 | input | 32 | Older instruction of the pair |
| in_insn1 | input | 32 | Younger instruction of the pair |
| ev_valid | output | 1 | Even pipe issues this cycle |
| ev_insn | output | 32 | Instruction sent to the even pipe |
| od_valid | output | 1 | Odd pipe issues this cycle |
| od_insn | output | 32 | Instruction sent to the odd pipe |
| rd_en | output | 6 | Read port enables |
| rd_addr | output | 42 | Read port register numbers, 7 bits each |
| rd_fwd | output | 6 | Take this operand from the forward path |
| rd_fwd_src | output | 6 | Forwarding write port per read port |
| wr_en | output | 2 | Write port enables (0 even, 1 odd) |
| wr_addr | output | 14 | Write port register numbers, 7 bits each |

## Verification
The bench aims at the pairing rule and its failure cases:
- two evens, and odd before even, where a design that pairs them would put two instructions on one pipe;
- a younger instruction that reads the older one's target, and a pair with equal targets, which must split;
- a busy register sitting only in an unused source slot, where a design that checks every slot would stall for nothing.

Across pairs, the bench measures the exact stall length behind a three-cycle even result and a two-cycle odd result. It checks that the dependent instruction leaves in the write-back cycle with the correct forward source, so an off-by-one scoreboard shows up as a wrong gap. It also checks that ready stays low for the whole stall, so a design that drops the second instruction would leave an expected issue missing.

// File: rtl/issue_pkg.sv
package issue_pkg;
  localparam int INSN_W = 32;
  localparam int RF_AW  = 7;
  localparam int NSLOT  = 3;

  typedef struct packed {
    logic                        odd;
    logic [NSLOT-1:0]            use_src;
    logic [RF_AW-1:0]            rt;
    logic [NSLOT-1:0][RF_AW-1:0] src;
  } dec_t;
endpackage

// File: rtl/iss_decode.sv
module iss_decode
  import issue_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output dec_t              dec
);
  logic [2:0] cnt;

  always_comb begin
    cnt         = insn[30:28];
    dec.odd     = insn[31];
    dec.rt      = insn[27:21];
    dec.src[0]  = insn[13:7];
    dec.src[1]  = insn[20:14];
    dec.src[2]  = insn[6:0];
    for (int k = 0; k < NSLOT; k++)
      dec.use_src[k] = (cnt > 3'(k));
  end
endmodule

// File: rtl/iss_scoreboard.sv
module iss_scoreboard #(
  parameter int NREG = 128,
  parameter int AW   = 7,
  parameter int LAT0 = 3,
  parameter int LAT1 = 2,
  parameter int NQ   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         set_en,
  input  logic [1:0][AW-1:0] set_addr,
  input  logic [NQ-1:0][AW-1:0] q_addr,
  output logic [NQ-1:0]      q_busy
);
  localparam int MAXLAT = (LAT0 > LAT1) ? LAT0 : LAT1;
  localparam int CW     = $clog2(MAXLAT + 1);

  logic [CW-1:0] cnt [NREG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) cnt[r] <= '0;
    end else begin
      for (int r = 0; r < NREG; r++) begin
        if (set_en[0] && set_addr[0] == AW'(r))      cnt[r] <= CW'(LAT0);
        else if (set_en[1] && set_addr[1] == AW'(r)) cnt[r] <= CW'(LAT1);
        else if (cnt[r] != '0)                       cnt[r] <= cnt[r] - 1'b1;
      end
    end
  end

  always_comb
    for (int q = 0; q < NQ; q++)
      q_busy[q] = (cnt[q_addr[q]] > CW'(1));

  // R7
  waw_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en[0] |-> cnt[set_addr[0]] <= CW'(1))
    else $error("even issue over in-flight target");
  // R7
  waw_odd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en[1] |-> cnt[set_addr[1]] <= CW'(1))
    else $error("odd issue over in-flight target");
  // R3
  pair_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en == 2'b11) |-> set_addr[0] != set_addr[1])
    else $error("paired issue with equal targets");
endmodule

// File: rtl/iss_wb_pipe.sv
module iss_wb_pipe #(
  parameter int DEPTH = 3,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_en,
  input  logic [AW-1:0] in_addr,
  output logic          out_en,
  output logic [AW-1:0] out_addr
);
  logic          st_v [DEPTH];
  logic [AW-1:0] st_a [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_v[i] <= 1'b0;
        st_a[i] <= '0;
      end
    end else begin
      st_v[0] <= in_en;
      st_a[0] <= in_addr;
      for (int i = 1; i < DEPTH; i++) begin
        st_v[i] <= st_v[i-1];
        st_a[i] <= st_a[i-1];
      end
    end
  end

  assign out_en   = st_v[DEPTH-1];
  assign out_addr = st_a[DEPTH-1];
endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
  import issue_pkg::*;
#(
  parameter int EVEN_LAT = 3,
  parameter int ODD_LAT  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [INSN_W-1:0]      in_insn0,
  input  logic [INSN_W-1:0]      in_insn1,
  output logic                   ev_valid,
  output logic [INSN_W-1:0]      ev_insn,
  output logic                   od_valid,
  output logic [INSN_W-1:0]      od_insn,
  output logic [2*NSLOT-1:0]     rd_en,
  output logic [2*NSLOT*RF_AW-1:0] rd_addr,
  output logic [2*NSLOT-1:0]     rd_fwd,
  output logic [2*NSLOT-1:0]     rd_fwd_src,
  output logic [1:0]             wr_en,
  output logic [2*RF_AW-1:0]     wr_addr
);
  localparam int NREG = 1 << RF_AW;
  localparam int NQ   = 2 * (NSLOT + 1);

  logic [1:0]              pend_q;
  logic [1:0][INSN_W-1:0]  insn_q;
  dec_t                    dec [2];
  logic [NQ-1:0][RF_AW-1:0] q_addr;
  logic [NQ-1:0]           q_busy;
  logic [1:0]              rdy, iss;
  logic                    raw_in_pair, pair_ok, accept;
  logic [1:0]              pv;
  logic [INSN_W-1:0]       pins [2];
  dec_t                    pd [2];

  // slot decoders
  for (genvar s = 0; s < 2; s++) begin : g_dec
    iss_decode u_dec (.insn(insn_q[s]), .dec(dec[s]));
  end

  // hazard queries: per slot, sources then target
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      for (int k = 0; k < NSLOT; k++) q_addr[s*(NSLOT+1)+k] = dec[s].src[k];
      q_addr[s*(NSLOT+1)+NSLOT] = dec[s].rt;
    end
  end

  iss_scoreboard #(.NREG(NREG), .AW(RF_AW), .LAT0(EVEN_LAT), .LAT1(ODD_LAT), .NQ(NQ)) u_sb (
    .clk(clk), .rst_n(rst_n),
    .set_en(pv), .set_addr({pd[1].rt, pd[0].rt}),
    .q_addr(q_addr), .q_busy(q_busy)
  );

  always_comb begin
    for (int s = 0; s < 2; s++)
      rdy[s] = !(|(q_busy[s*(NSLOT+1) +: NSLOT] & dec[s].use_src)) &&
               !q_busy[s*(NSLOT+1)+NSLOT];
    raw_in_pair = 1'b0;
    for (int k = 0; k < NSLOT; k++)
      if (dec[1].use_src[k] && dec[1].src[k] == dec[0].rt) raw_in_pair = 1'b1;
    pair_ok = !dec[0].odd && dec[1].odd && !raw_in_pair && (dec[1].rt != dec[0].rt);
    iss[0]  = pend_q[0] && rdy[0];
    iss[1]  = pend_q[1] && rdy[1] && (pend_q[0] ? (iss[0] && pair_ok) : 1'b1);
    in_ready = ((pend_q & ~iss) == 2'b00);
    accept   = in_valid && in_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 2'b00;
      insn_q <= '0;
    end else if (accept) begin
      pend_q <= 2'b11;
      insn_q <= {in_insn1, in_insn0};
    end else begin
      pend_q <= pend_q & ~iss;
    end
  end

  // pipe steering, read ports and write-back lines
  for (genvar p = 0; p < 2; p++) begin : g_pipe
    logic from0, from1;
    assign from0   = iss[0] && (dec[0].odd == 1'(p));
    assign from1   = iss[1] && (dec[1].odd == 1'(p));
    assign pv[p]   = from0 || from1;
    assign pins[p] = from0 ? insn_q[0] : insn_q[1];
    assign pd[p]   = from0 ? dec[0] : dec[1];

    iss_wb_pipe #(.DEPTH(p == 0 ? EVEN_LAT : ODD_LAT), .AW(RF_AW)) u_wb (
      .clk(clk), .rst_n(rst_n),
      .in_en(pv[p]), .in_addr(pd[p].rt),
      .out_en(wr_en[p]), .out_addr(wr_addr[p*RF_AW +: RF_AW])
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_port
      localparam int PI = p*NSLOT + k;
      logic m0, m1, en;
      assign en = pv[p] && pd[p].use_src[k];
      assign m0 = wr_en[0] && wr_addr[0 +: RF_AW]     == pd[p].src[k];
      assign m1 = wr_en[1] && wr_addr[RF_AW +: RF_AW] == pd[p].src[k];
      assign rd_en[PI]                   = en;
      assign rd_addr[PI*RF_AW +: RF_AW]  = pd[p].src[k];
      assign rd_fwd[PI]                  = en && (m0 || m1);
      assign rd_fwd_src[PI]              = m1 && !m0;
    end
  end

  assign ev_valid = pv[0];
  assign ev_insn  = pins[0];
  assign od_valid = pv[1];
  assign od_insn  = pins[1];

  // R10
  wr_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == 2'b11) |-> wr_addr[0 +: RF_AW] != wr_addr[RF_AW +: RF_AW])
    else $error("both write ports on one register");
  // R2
  even_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> !ev_insn[31])
    else $error("odd-class instruction on even pipe");
  // R2
  odd_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    od_valid |-> od_insn[31])
    else $error("even-class instruction on odd pipe");
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (ev_valid || od_valid || !in_ready))
    else $error("accepted pair neither issued nor held");
endmodule

// File: tb/pair_issue_unit_tb_top.sv
module pair_issue_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn0 = '0, in_insn1 = '0;
  logic        ev_valid, od_valid;
  logic [31:0] ev_insn, od_insn;
  logic [5:0]  rd_en, rd_fwd, rd_fwd_src;
  logic [41:0] rd_addr;
  logic [1:0]  wr_en;
  logic [13:0] wr_addr;

  int checks = 0, errors = 0;
  int cyc = 0, last_cyc = 0;
  bit fin = 1'b0;

  typedef struct {
    logic [31:0] insn;
    int          delta;
    logic [2:0]  fwd;
    logic [2:0]  fsrc;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pair_issue_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn0(in_insn0), .in_insn1(in_insn1),
    .ev_valid(ev_valid), .ev_insn(ev_insn), .od_valid(od_valid), .od_insn(od_insn),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_fwd(rd_fwd), .rd_fwd_src(rd_fwd_src),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R1 encoding: class, count, rt, rb, ra, rc
  function automatic logic [31:0] mk(bit odd, int n, int rt, int ra, int rb, int rc);
    return {odd, 3'(n), 7'(rt), 7'(rb), 7'(ra), 7'(rc)};
  endfunction

  function automatic logic [6:0] slot_reg(logic [31:0] i, int k);
    return (k == 0) ? i[13:7] : (k == 1) ? i[20:14] : i[6:0];
  endfunction

  task automatic expect_issue(logic [31:0] i, int delta, logic [2:0] fwd, logic [2:0] fsrc);
    exp_t e;
    e.insn = i; e.delta = delta; e.fwd = fwd; e.fsrc = fsrc;
    exp_q.push_back(e);
  endtask

  task automatic send(logic [31:0] i0, logic [31:0] i1);
    in_insn0 = i0; in_insn1 = i1; in_valid = 1'b1;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (5) @(negedge clk);
  endtask

  // monitor: pops expected issues in program order (even before odd in a cycle)
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      for (int p = 0; p < 2; p++) begin
        logic v; logic [31:0] ins;
        v   = p ? od_valid : ev_valid;
        ins = p ? od_insn  : ev_insn;
        if (v) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R4 unexpected issue", ins, 0);
          end else begin
            exp_t e; int n;
            e = exp_q.pop_front();
            chk(ins == e.insn, "R4 program order", ins, e.insn);
            chk(int'(e.insn[31]) == p, "R2 pipe steering", p, e.insn[31]);
            if (e.delta >= 0)
              chk(cyc - last_cyc == e.delta, "R3/R5/R7 issue gap", cyc - last_cyc, e.delta);
            last_cyc = cyc;
            n = (e.insn[30:28] > 3) ? 3 : int'(e.insn[30:28]);
            for (int k = 0; k < 3; k++) begin
              int pi; logic fs;
              pi = p*3 + k;
              chk(rd_en[pi] == (k < n), "R8 R6 read enable", rd_en[pi], k < n);
              if (k < n) begin
                chk(rd_addr[pi*7 +: 7] == slot_reg(e.insn, k), "R8 read address",
                    rd_addr[pi*7 +: 7], slot_reg(e.insn, k));
                chk(rd_fwd[pi] == e.fwd[k], "R9 bypass select", rd_fwd[pi], e.fwd[k]);
                if (e.fwd[k]) begin
                  fs = e.fsrc[k];
                  chk(rd_fwd_src[pi] == fs, "R9 bypass source", rd_fwd_src[pi], fs);
                  chk(wr_en[fs] && wr_addr[fs*7 +: 7] == slot_reg(e.insn, k),
                      "R10 write port timing", {wr_en[fs], wr_addr[fs*7 +: 7]},
                      {1'b1, slot_reg(e.insn, k)});
                end
              end
            end
          end
        end else begin
          chk(rd_en[p*3 +: 3] == 3'b000, "R8 idle pipe reads", rd_en[p*3 +: 3], 0);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, c, d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(in_ready == 1'b1, "R12 ready after reset", in_ready, 1);
    chk({ev_valid, od_valid} == 2'b00, "R12 no issue after reset", {ev_valid, od_valid}, 0);
    chk(wr_en == 2'b00 && rd_en == 6'd0, "R12 no port activity", {wr_en, rd_en}, 0);

    // R3 independent even+odd pairs stream at one pair per cycle (R11)
    a = mk(0, 3, 1, 10, 11, 12); b = mk(1, 3, 2, 20, 21, 22);
    c = mk(0, 2, 3, 13, 14, 0);  d = mk(1, 1, 4, 23, 0, 0);
    expect_issue(a, -1, 0, 0); expect_issue(b, 0, 0, 0);
    expect_issue(c, 1, 0, 0);  expect_issue(d, 0, 0, 0);
    send(a, b); send(c, d); in_valid = 1'b0;
    wait_idle();

    // R3 R4 two evens split; count 6 saturates to 3 sources (R1)
    a = mk(0, 6, 5, 60, 61, 62); b = mk(0, 0, 6, 0, 0, 0);
    expect_issue(a, -1, 0, 0); expect_issue(b, 1, 0, 0);
    send(a, b); in_valid = 1'b0;
    wait_idle();

    // R3 R4 odd before even splits
    a = mk(1, 2, 7, 63, 64, 0); b = mk(0, 1, 8, 65, 0, 0);
    expect_issue(a, -1, 0, 0); expect_issue(b, 1, 0, 0);
    send(a, b); in_valid = 1'b0;
    wait_idle();

    // R5 R9 R11 in-pair RAW: second waits for even write-back, ready held low
    a = mk(0, 0, 9, 0, 0, 0); b = mk(1, 1, 10, 9, 0, 0);
    expect_issue(a, -1, 0, 0); expect_issue(b, 3, 3'b001, 3'b000);
    send(a, b); in_valid = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(in_ready == 1'b0, "R11 ready low during stall", in_ready, 0);
      @(negedge clk);
    end
    chk(in_ready == 1'b1, "R11 ready when last issues", in_ready, 1);
    wait_idle();

    // R6 busy register only in unused slots: pair still dual-issues
    a = mk(0, 0, 15, 0, 0, 0); b = mk(1, 1, 16, 31, 15, 15);
    expect_issue(a, -1, 0, 0); expect_issue(b, 0, 0, 0);
    send(a, b); in_valid = 1'b0;
    wait_idle();

    // R5 R9 cross-pair stalls with forwarding from each write port
    a = mk(0, 0, 40, 0, 0, 0); b = mk(1, 0, 41, 0, 0, 0);
    c = mk(0, 1, 42, 41, 0, 0); d = mk(1, 1, 43, 40, 0, 0);
    expect_issue(a, -1, 0, 0); expect_issue(b, 0, 0, 0);
    expect_issue(c, 2, 3'b001, 3'b001); expect_issue(d, 1, 3'b001, 3'b000);
    send(a, b); send(c, d); in_valid = 1'b0;
    wait_idle();

    // R7 R3 equal targets split and the younger waits for the older write
    a = mk(0, 0, 50, 0, 0, 0); b = mk(1, 0, 50, 0, 0, 0);
    expect_issue(a, -1, 0, 0); expect_issue(b, 3, 0, 0);
    send(a, b); in_valid = 1'b0;
    wait_idle();

    chk(exp_q.size() == 0, "R4 all instructions issued", exp_q.size(), 0);
    fin = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule